// File: doc/BRIEF.md
# Byte-Masked Wake Frame Matcher

The block watches a received byte stream and decides whether a frame matches any of four programmable wake patterns. Each pattern is given as a starting byte offset into the frame, a 64-bit mask over a 64-byte window that begins at that offset, and a 16-bit reference checksum. The bytes that the mask selects are folded into a per-filter CRC. When the frame ends, each filter compares its CRC with its reference, and the matching filters are recorded in a sticky hit vector.

Bytes arrive one per cycle with a valid strobe and with start and end markers on the first and last byte. Software programs the filters and clears hits through a word-wide write port. A single wake output is the OR of the hit vector. Software reads the hit vector to see which pattern woke the system, then clears it.

Top module: `wake_frame_matcher`

## Requirements
- R1: After reset every offset, mask and reference register is zero, `hits_o` is 0 and `wake_o` is 0.
- R2: Writes with `cfg_addr_i[4]`=0 select filter `cfg_addr_i[3:2]` and a field by `cfg_addr_i[1:0]`. 0 is the offset (`wdata[7:0]`). 1 is mask bits 31:0. 2 is mask bits 63:32. 3 is the reference (`wdata[15:0]`).
- R3: Mask bit k selects window byte k, which is frame byte offset+k, for k from 0 to 63. Frame byte 0 is the byte carrying `sof_i`. Selected bytes update a CRC-16 that uses polynomial 0x8005 and seed 0xFFFF. The CRC takes each byte MSB first, with no reflection and no final inversion.
- R4: The comparison includes the byte marked `eof_i`. A matching filter sets its `hits_o` bit in the cycle after that byte is accepted.
- R5: A filter whose mask is all zeros never sets its hit bit, whatever its reference value.
- R6: A frame that ends before its window is complete is compared using only the selected bytes that were received.
- R7: A hit bit stays set until a write to address 0x10 with a 1 in that bit position. Zero bits in that write leave their hits unchanged. `wake_o` is high whenever any hit bit is set.
- R8: A valid byte that arrives outside a frame (no `sof_i`, no frame open) has no effect.
- R9: A byte with `sof_i` while a frame is open abandons that frame and starts a new one at byte 0.
- R10: The four filters work independently, and several may set their hit bits at the end of the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| valid_i | input | 1 | Received byte valid |
| sof_i | input | 1 | Byte is the first of a frame |
| eof_i | input | 1 | Byte is the last of a frame |
| data_i | input | 8 | Received byte |
| hits_o | output | 4 | Sticky per-filter match vector |
| wake_o | output | 1 | Any filter has matched |

## Verification
The hardest case to reach from the ports is a frame whose selected bytes fold to exactly the stored reference. Random references almost never match. The bench therefore computes the CRC of each generated frame under each filter's window and mask. For about half the filters it writes that value as the reference before sending the frame, so matches and non-matches are both common. Directed frames cover the remaining corners. These include a stray end-marked byte that would complete a match if it were accepted, a zero mask with a reference equal to the seed, a window cut short by the end of the frame, and a restart in the middle of a frame.

// File: rtl/wkm_pkg.sv
package wkm_pkg;
  localparam int          WIN      = 64;
  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c_in,
                                                  input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/wkm_cfg.sv
module wkm_cfg
  import wkm_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int OFFS_W   = 8,
  parameter int ADDR_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [31:0]                     wdata_i,
  output logic [NUM_FILT-1:0][OFFS_W-1:0] offset_o,
  output logic [NUM_FILT-1:0][WIN-1:0]    mask_o,
  output logic [NUM_FILT-1:0][CRC_W-1:0]  crc_ref_o
);
  localparam int SEL_W = ADDR_W - 3;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_reg
    logic hit_f;
    assign hit_f = we_i && !addr_i[ADDR_W-1] && (addr_i[ADDR_W-2:2] == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        offset_o[g]  <= '0;
        mask_o[g]    <= '0;
        crc_ref_o[g] <= '0;
      end else if (hit_f) begin
        case (addr_i[1:0])
          2'd0: offset_o[g]            <= wdata_i[OFFS_W-1:0];
          2'd1: mask_o[g][31:0]        <= wdata_i;
          2'd2: mask_o[g][WIN-1:32]    <= wdata_i;
          default: crc_ref_o[g]        <= wdata_i[CRC_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/wkm_frame.sv
module wkm_frame #(
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             fire_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             in_frame_q;
  logic [IDX_W-1:0] idx_q;

  assign fire_o = valid_i && (sof_i || in_frame_q);
  assign sof_o  = valid_i && sof_i;
  assign eof_o  = fire_o && eof_i;
  assign idx_o  = sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else if (fire_o) begin
      in_frame_q <= !eof_i;
      idx_q      <= (idx_o == IDX_MAX) ? IDX_MAX : idx_o + 1'b1;
    end
  end

  AST_IDX_AFTER_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> (idx_q == IDX_W'(1)));  // R9
  AST_STRAY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sof_i && !in_frame_q) |=> ($stable(idx_q) && !in_frame_q));  // R8
endmodule

// File: rtl/wkm_filter.sv
module wkm_filter
  import wkm_pkg::*;
#(
  parameter int OFFS_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [WIN-1:0]    mask_i,
  input  logic [CRC_W-1:0]  crc_ref_i,
  input  logic              fire_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        data_i,
  output logic              match_o
);
  localparam int WIN_W = $clog2(WIN);

  logic [CRC_W-1:0] crc_q, crc_base, crc_next;
  logic [IDX_W:0]   rel;
  logic             in_win, take;

  assign rel      = {1'b0, idx_i} - (IDX_W+1)'(offset_i);
  assign in_win   = ({1'b0, idx_i} >= (IDX_W+1)'(offset_i)) && (rel < (IDX_W+1)'(WIN));
  assign take     = in_win && mask_i[rel[WIN_W-1:0]];
  assign crc_base = sof_i ? CRC_SEED : crc_q;
  assign crc_next = take ? crc16_byte(crc_base, data_i) : crc_base;
  assign match_o  = eof_i && (|mask_i) && (crc_next == crc_ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (fire_i) crc_q <= crc_next;
  end

  AST_CRC_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(crc_q));  // R8
endmodule

// File: rtl/wake_frame_matcher.sv
module wake_frame_matcher
  import wkm_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int OFFS_W   = 8,
  parameter int IDX_W    = OFFS_W + 1,
  parameter int ADDR_W   = $clog2(NUM_FILT) + 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [31:0]         cfg_wdata_i,
  input  logic                valid_i,
  input  logic                sof_i,
  input  logic                eof_i,
  input  logic [7:0]          data_i,
  output logic [NUM_FILT-1:0] hits_o,
  output logic                wake_o
);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  logic [NUM_FILT-1:0][OFFS_W-1:0] offset;
  logic [NUM_FILT-1:0][WIN-1:0]    mask;
  logic [NUM_FILT-1:0][CRC_W-1:0]  crc_ref;
  logic [NUM_FILT-1:0]             match, hits_q;
  logic                            fire, sof_acc, eof_acc, clr_we;
  logic [IDX_W-1:0]                idx;

  wkm_cfg #(.NUM_FILT(NUM_FILT), .OFFS_W(OFFS_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .offset_o(offset), .mask_o(mask), .crc_ref_o(crc_ref)
  );

  wkm_frame #(.IDX_W(IDX_W)) u_frame (
    .clk_i, .rst_ni, .valid_i, .sof_i, .eof_i,
    .fire_o(fire), .sof_o(sof_acc), .eof_o(eof_acc), .idx_o(idx)
  );

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    wkm_filter #(.OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_filt (
      .clk_i, .rst_ni, .offset_i(offset[g]), .mask_i(mask[g]), .crc_ref_i(crc_ref[g]),
      .fire_i(fire), .sof_i(sof_acc), .eof_i(eof_acc), .idx_i(idx), .data_i,
      .match_o(match[g])
    );

    AST_ZERO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hits_q[g]) |-> $past(mask[g] != '0));  // R5
  end

  assign clr_we = cfg_we_i && (cfg_addr_i == CLR_ADDR);

  // a new hit wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hits_q <= '0;
    else         hits_q <= (hits_q & ~({NUM_FILT{clr_we}} & cfg_wdata_i[NUM_FILT-1:0]))
                           | match;
  end

  assign hits_o = hits_q;
  assign wake_o = |hits_q;

  AST_HIT_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hits_q & ~$past(hits_q))) |-> $past(eof_acc));  // R4
  AST_HIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(hits_q) & ~hits_q)) |-> $past(clr_we));  // R7
endmodule

// File: tb/wake_frame_matcher_tb.sv
module wake_frame_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        valid = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0]  data = '0;
  logic [3:0]  hits;
  logic        wake;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  fbuf [0:127];
  logic [7:0]  m_off [0:3];
  logic [63:0] m_mask [0:3];
  logic [15:0] m_ref [0:3];
  logic [3:0]  exp_hits;

  always #10 clk = ~clk;

  wake_frame_matcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .hits_o(hits), .wake_o(wake)
  );

  function automatic logic [15:0] ref_crc(int len, logic [7:0] off, logic [63:0] msk);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < 64; k++) begin
      int p = int'(off) + k;
      if (p < len && msk[k]) begin
        for (int b = 7; b >= 0; b--) begin
          logic top = c[15] ^ fbuf[p][b];
          c = {c[14:0], 1'b0} ^ (top ? 16'h8005 : 16'h0000);
        end
      end
    end
    return c;
  endfunction

  function automatic logic [3:0] ref_match(int len);
    logic [3:0] v = '0;
    for (int f = 0; f < 4; f++)
      v[f] = (m_mask[f] != 64'd0) && (ref_crc(len, m_off[f], m_mask[f]) == m_ref[f]);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_filt(int f, logic [7:0] off, logic [63:0] msk, logic [15:0] r);
    m_off[f] = off; m_mask[f] = msk; m_ref[f] = r;
    wr(5'(f*4 + 0), {24'd0, off});
    wr(5'(f*4 + 1), msk[31:0]);
    wr(5'(f*4 + 2), msk[63:32]);
    wr(5'(f*4 + 3), {16'd0, r});
  endtask

  // send fbuf[0..len-1]; ends at the negedge after the last byte
  task automatic send(int len, bit with_eof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid = 1'b1; sof = (i == 0); eof = with_eof && (i == len - 1); data = fbuf[i];
    end
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; eof = 1'b0;
  endtask

  task automatic clear_all();
    wr(5'h10, 32'hF);
    exp_hits = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    exp_hits = '0;
    for (int f = 0; f < 4; f++) begin m_off[f] = '0; m_mask[f] = '0; m_ref[f] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hits after reset", 32'(hits), 0);
    check("R1 wake after reset", 32'(wake), 0);

    // R1: zero registers with reference 0 -> no hit on any frame
    for (int i = 0; i < 8; i++) fbuf[i] = 8'(i * 17);
    send(8, 1);
    check("R1 zeroed filters", 32'(hits), 0);

    // R3/R4: filter 0, bytes 0..5
    for (int i = 0; i < 20; i++) fbuf[i] = 8'(8'h30 + i);
    set_filt(0, 8'd0, 64'h3F, ref_crc(20, 8'd0, 64'h3F));
    send(20, 1);
    check("R3 R4 filter0 hit", 32'(hits), 32'h1);
    check("R7 wake follows hit", 32'(wake), 1);
    exp_hits = 4'h1;

    // R7: non-matching frame keeps hit; zero bits in clear ignored
    fbuf[2] = 8'hEE;
    send(20, 1);
    check("R7 hit held", 32'(hits), 32'h1);
    wr(5'h10, 32'hE);
    check("R7 zero bits leave hit", 32'(hits), 32'h1);
    wr(5'h10, 32'h1);
    check("R7 clear by one", 32'(hits), 0);
    check("R7 wake cleared", 32'(wake), 0);

    // R3: wrong reference
    fbuf[2] = 8'h32;
    m_ref[0] = ref_crc(20, 8'd0, 64'h3F) ^ 16'h0001;
    wr(5'h03, {16'd0, m_ref[0]});
    send(20, 1);
    check("R3 wrong reference", 32'(hits), 0);

    // R5: zero mask, reference equal to seed
    set_filt(0, 8'd0, 64'd0, 16'hFFFF);
    send(20, 1);
    check("R5 zero mask never hits", 32'(hits), 0);

    // R2/R3: filter 1 offset 12, selected bytes only in upper mask word
    for (int i = 0; i < 100; i++) fbuf[i] = 8'((i * 37) ^ 8'h5A);
    set_filt(1, 8'd12, 64'h0000_000F_0000_0000, ref_crc(100, 8'd12, 64'h0000_000F_0000_0000));
    send(100, 1);
    check("R2 R3 upper mask word offset", 32'(hits), 32'h2);
    fbuf[13] = ~fbuf[13]; // unselected byte inside window
    clear_all();
    send(100, 1);
    check("R3 unselected byte no effect", 32'(hits), 32'h2);
    fbuf[44] = ~fbuf[44]; // selected byte (window 32)
    clear_all();
    send(100, 1);
    check("R3 selected byte changes crc", 32'(hits), 0);
    fbuf[44] = ~fbuf[44]; fbuf[13] = ~fbuf[13];

    // R6: short frame, window cut at byte 30
    set_filt(2, 8'd20, 64'hFFFF_FFFF_FFFF_FFFF, ref_crc(30, 8'd20, 64'hFFFF_FFFF_FFFF_FFFF));
    clear_all();
    send(30, 1);
    check("R6 short frame", 32'(hits), 32'h4);

    // R10: filters 1,2,3 in one frame
    set_filt(2, 8'd5, 64'h00F0_0000_0000_FF01, ref_crc(100, 8'd5, 64'h00F0_0000_0000_FF01));
    set_filt(3, 8'd0, 64'h1, ref_crc(100, 8'd0, 64'h1));
    clear_all();
    send(100, 1);
    check("R10 simultaneous hits", 32'(hits), 32'hE);

    // R8: stray end-marked byte after a frame would match if accepted
    fbuf[0] = 8'hAB; fbuf[1] = 8'h01;
    set_filt(1, 8'd0, 64'd0, 16'd0);
    set_filt(2, 8'd0, 64'd0, 16'd0);
    set_filt(3, 8'd0, 64'h1, ref_crc(2, 8'd0, 64'h1));
    clear_all();
    send(2, 1);
    check("R8 setup hit", 32'(hits), 32'h8);
    wr(5'h10, 32'h8);
    @(negedge clk);
    valid = 1'b1; sof = 1'b0; eof = 1'b1; data = 8'hAB;
    @(negedge clk);
    valid = 1'b0; eof = 1'b0;
    check("R8 stray byte ignored", 32'(hits), 0);

    // R9: restart mid-frame
    for (int i = 0; i < 10; i++) fbuf[i] = 8'(8'hC0 + i);
    set_filt(3, 8'd2, 64'h1F, ref_crc(10, 8'd2, 64'h1F));
    for (int i = 0; i < 10; i++) fbuf[i] = 8'h99;
    send(6, 0); // open frame, never ended
    for (int i = 0; i < 10; i++) fbuf[i] = 8'(8'hC0 + i);
    send(10, 1);
    check("R9 restart on new start", 32'(hits), 32'h8);
    clear_all();

    // random frames
    for (int n = 0; n < 40; n++) begin
      int len = 1 + int'($urandom_range(0, 90));
      logic [3:0] v;
      for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
      for (int f = 0; f < 4; f++) begin
        logic [7:0]  o = 8'($urandom_range(0, 24));
        logic [63:0] mk = {32'($urandom), 32'($urandom)};
        logic [15:0] r;
        if ($urandom_range(0, 7) == 0) mk = '0;
        r = ($urandom_range(0, 1) == 1) ? ref_crc(len, o, mk) : 16'($urandom);
        set_filt(f, o, mk, r);
      end
      v = ref_match(len);
      send(len, 1);
      exp_hits = exp_hits | v;
      check("R3 R4 R10 random frame hits", 32'(hits), 32'(exp_hits));
      check("R7 random wake", 32'(wake), 32'(|exp_hits));
      clear_all();
    end

    finish_run();
  end
endmodule